// File: doc/BRIEF.md
# Booth Radix-2 Sequential Signed Multiplier

This block multiplies two signed two's complement operands of `W` bits each and returns the full `2W`-bit signed product. It retires one Booth-recoded multiplier bit per clock. A controller looks at the lowest multiplier bit and the bit shifted out last. From that pair it chooses to add the multiplicand to the running accumulator, subtract it, or leave the accumulator alone. It then shifts the accumulator, the multiplier and the shifted-out bit one place right, keeping the sign. Negative operands need no pre- or post-correction. The most negative multiplicand is handled by an accumulator that is wider than the operand.

A client holds the operands and pulses `start` while the block is idle. The operands are captured on that edge. The block then runs `W` iteration cycles and raises `done` for one cycle with the product valid. The product stays on the output until the next accepted `start`. A `start` that arrives while the block is busy is dropped.

The controller has three states. `ST_IDLE` waits. `ST_STEP` performs one recode, add or subtract, and shift per cycle. `ST_DONE` presents the result. There are four transitions:
- LAUNCH goes from `ST_IDLE` to `ST_STEP` on `start`, loading the operands and setting the counter to `W`.
- ITERATE goes from `ST_STEP` to `ST_STEP` while more than one iteration remains.
- FINISH goes from `ST_STEP` to `ST_DONE` on the last iteration.
- RETIRE goes from `ST_DONE` to `ST_IDLE` unconditionally.

Top module: `booth_seq_mul`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `busy` and `done` are 0 and `product` is 0.
- R2: A `start` sampled high while `busy` is 0 is accepted. `busy` is 1 from the next cycle, and `done` is 1 exactly `W+1` cycles after the accepting edge.
- R3: `done` is high for exactly one cycle, and `busy` is 0 in the cycle after `done`.
- R4: When `done` is 1, `product` equals the signed product of the `mcand` and `mplier` values captured at acceptance, as a `2W`-bit two's complement value. This holds for every sign combination.
- R5: Operands equal to the most negative value -2^(W-1) give exact products. This includes (-2^(W-1)) x (-2^(W-1)) = 2^(2W-2).
- R6: A `start` while `busy` is 1 is ignored. Changing the operands during a run alters neither the result nor the timing.
- R7: While idle, `product` holds the last result (0 after reset) until the next accepted `start`, whatever `mcand` and `mplier` do.
- R8: With W=4, multiplicand 7 and multiplier 3 give product 8'h15: the upper half 0001 and the lower half 0101.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a multiplication; honoured only while idle |
| mcand | input | W | Multiplicand, two's complement |
| mplier | input | W | Multiplier, two's complement |
| busy | output | 1 | High from acceptance through the done cycle |
| done | output | 1 | One-cycle pulse; product valid |
| product | output | 2W | Signed product, held until the next accepted start |

## Verification
At W=4, every one of the 256 operand pairs is run. This separates a wrong recode choice for any bit pattern, such as swapped add and subtract or a skipped 11 pair, from a correct one. At W=8 and W=16, random pairs plus the extreme values exercise long runs of ones and sign flips. These cases also expose a sum that wraps for lack of guard bits and a shift that fills with zero instead of the sign. Some runs toggle `start` and scramble the operands while busy, and idle gaps scramble the operands again. These runs distinguish a design that captures its inputs once from one that keeps reading them.

// File: rtl/booth_pkg.sv
package booth_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_STEP,
        ST_DONE
    } booth_state_e;

    typedef enum logic [1:0] {
        OP_SKIP,
        OP_ADD,
        OP_SUB
    } booth_op_e;

endpackage

// File: rtl/booth_recode.sv
module booth_recode
    import booth_pkg::*;
(
    input  logic      q_lsb,
    input  logic      q_prev,
    output booth_op_e op
);

    always_comb begin
        unique case ({q_lsb, q_prev})
            2'b10:   op = OP_SUB;
            2'b01:   op = OP_ADD;
            default: op = OP_SKIP;
        endcase
    end

endmodule

// File: rtl/booth_step.sv
module booth_step
    import booth_pkg::*;
#(
    parameter int W  = 8,
    parameter int AW = W + 2
) (
    input  logic [AW-1:0] acc,
    input  logic [W-1:0]  mq,
    input  logic [W-1:0]  mcand,
    input  booth_op_e     op,
    output logic [AW-1:0] acc_nx,
    output logic [W-1:0]  mq_nx,
    output logic          q_prev_nx
);

    logic [AW-1:0] m_ext;
    logic [AW-1:0] sum;

    assign m_ext = {{(AW-W){mcand[W-1]}}, mcand};

    always_comb begin
        unique case (op)
            OP_ADD:  sum = acc + m_ext;
            OP_SUB:  sum = acc - m_ext;
            default: sum = acc;
        endcase
    end

    // arithmetic right shift across {acc, mq, q_prev}
    assign acc_nx    = {sum[AW-1], sum[AW-1:1]};
    assign mq_nx     = {sum[0], mq[W-1:1]};
    assign q_prev_nx = mq[0];

endmodule

// File: rtl/booth_seq_mul.sv
module booth_seq_mul
    import booth_pkg::*;
#(
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [W-1:0]   mcand,
    input  logic [W-1:0]   mplier,
    output logic           busy,
    output logic           done,
    output logic [2*W-1:0] product
);

    localparam int AW = W + 2;
    localparam int CW = $clog2(W + 1);

    booth_state_e  state, state_nx;
    logic [AW-1:0] acc;
    logic [W-1:0]  mq;
    logic          q_prev;
    logic [W-1:0]  m_reg;
    logic [CW-1:0] cnt;

    booth_op_e     op;
    logic [AW-1:0] acc_nx;
    logic [W-1:0]  mq_nx;
    logic          q_prev_nx;
    logic          last_iter;

    booth_recode u_recode (
        .q_lsb  (mq[0]),
        .q_prev (q_prev),
        .op     (op)
    );

    booth_step #(.W(W), .AW(AW)) u_step (
        .acc       (acc),
        .mq        (mq),
        .mcand     (m_reg),
        .op        (op),
        .acc_nx    (acc_nx),
        .mq_nx     (mq_nx),
        .q_prev_nx (q_prev_nx)
    );

    assign last_iter = (cnt == CW'(1));

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (start)     state_nx = ST_STEP;
            ST_STEP: if (last_iter) state_nx = ST_DONE;
            ST_DONE:                state_nx = ST_IDLE;
            default:                state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc    <= '0;
            mq     <= '0;
            q_prev <= 1'b0;
            m_reg  <= '0;
            cnt    <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (start) begin
                    acc    <= '0;
                    mq     <= mplier;
                    q_prev <= 1'b0;
                    m_reg  <= mcand;
                    cnt    <= CW'(W);
                end
                ST_STEP: begin
                    acc    <= acc_nx;
                    mq     <= mq_nx;
                    q_prev <= q_prev_nx;
                    cnt    <= cnt - 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        busy = (state != ST_IDLE);
        done = (state == ST_DONE);
    end

    assign product = {acc[W-1:0], mq};

endmodule

// File: rtl/booth_seq_mul_chk.sv
module booth_seq_mul_chk #(
    parameter int W = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start,
    input logic [W-1:0]   mcand,
    input logic [W-1:0]   mplier,
    input logic           busy,
    input logic           done,
    input logic [2*W-1:0] product
);

    localparam int LW = $clog2(W + 3) + 1;

    logic [LW-1:0]         lat;
    logic signed [W-1:0]   cap_a, cap_b;
    logic signed [2*W-1:0] ref_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat   <= '0;
            cap_a <= '0;
            cap_b <= '0;
        end else if (!busy && start) begin
            lat   <= LW'(1);
            cap_a <= mcand;
            cap_b <= mplier;
        end else if (busy) begin
            lat <= lat + 1'b1;
        end
    end

    always_comb ref_p = cap_a * cap_b;

    // R2
    start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy);

    // R2
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (lat == LW'(W + 1)));

    // R3
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R3
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    // R4
    product_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (product == ref_p));

    // R6
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    // R7
    product_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(product));

endmodule

bind booth_seq_mul booth_seq_mul_chk #(.W(W)) u_chk (.*);

// File: tb/sim_booth_seq_mul.sv
`timescale 1ns/1ps

module sim_lane #(
    parameter int W     = 4,
    parameter bit EXH   = 1'b1,
    parameter int NRAND = 0
) (
    input  logic clk,
    input  logic rst_n,
    output int   total,
    output int   bad,
    output logic fin
);

    logic           start;
    logic [W-1:0]   mcand, mplier;
    logic           busy, done;
    logic [2*W-1:0] product;

    booth_seq_mul #(.W(W)) u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .mcand   (mcand),
        .mplier  (mplier),
        .busy    (busy),
        .done    (done),
        .product (product)
    );

    // behavioural reference: 0 idle, 1 running, 2 result cycle
    int                    phase = 0;
    int                    left  = 0;
    bit                    armed = 1'b0;
    logic signed [2*W-1:0] exp_p = '0;
    logic signed [2*W-1:0] held  = '0;
    string                 tag   = "R4";

    always @(posedge clk) begin
        armed = 1'b1;
        if (!rst_n) begin
            phase = 0;
            held  = '0;
        end else begin
            case (phase)
                0: if (start) begin
                    exp_p = $signed(mcand) * $signed(mplier);
                    tag   = "R4";
                    if (mcand == {1'b1, {(W-1){1'b0}}} || mplier == {1'b1, {(W-1){1'b0}}})
                        tag = "R5";
                    if (W == 4 && mcand == W'(7) && mplier == W'(3))
                        tag = "R8";
                    left  = W;
                    phase = 1;
                end
                1: begin
                    if (start) tag = "R6";
                    left = left - 1;
                    if (left == 0) phase = 2;
                end
                default: begin
                    held  = exp_p;
                    phase = 0;
                end
            endcase
        end
    end

    task automatic check(input bit ok, input string rq, input longint act, input longint expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s W=%0d t=%0t actual=%0h expected=%0h", rq, W, $time, act, expv);
        end
    endtask

    always @(negedge clk) begin
        if (armed) begin
            check(busy == (phase != 0), (!rst_n) ? "R1" : "R2", longint'(busy), longint'(phase != 0));
            check(done == (phase == 2), (!rst_n) ? "R1" : "R3", longint'(done), longint'(phase == 2));
            if (phase == 0)
                check(product == held, (!rst_n) ? "R1" : "R7", longint'(product), longint'(held));
            else if (phase == 2)
                check(product == exp_p, tag, longint'(product), longint'(exp_p));
        end
    end

    task automatic do_op(input logic [W-1:0] a, input logic [W-1:0] b, input bit noisy);
        mcand  = a;
        mplier = b;
        start  = 1'b1;
        @(negedge clk);
        if (noisy) begin
            // R6: request and operand changes while busy
            mcand  = ~a;
            mplier = b + 1'b1;
            repeat (2) @(negedge clk);
        end
        start  = 1'b0;
        mcand  = W'($urandom);
        mplier = W'($urandom);
        while (phase != 0) @(negedge clk);
        // R7: idle gap with scrambled operands
        if ($urandom % 3 == 0) begin
            mcand  = W'($urandom);
            mplier = W'($urandom);
            @(negedge clk);
        end
    endtask

    initial begin
        logic [W-1:0] mn, mx;
        total  = 0;
        bad    = 0;
        fin    = 1'b0;
        start  = 1'b0;
        mcand  = '0;
        mplier = '0;
        mn     = {1'b1, {(W-1){1'b0}}};
        mx     = ~mn;
        @(posedge rst_n);
        @(negedge clk);
        // R8 first when W is 4
        do_op(W'(7), W'(3), 1'b0);
        // R5 corners
        do_op(mn, mn, 1'b0);
        do_op(mn, '1, 1'b0);
        do_op(mn, mx, 1'b1);
        do_op(mx, mn, 1'b0);
        do_op(mx, mx, 1'b0);
        do_op('0, mn, 1'b0);
        if (EXH) begin
            for (int a = 0; a < (1 << W); a++)
                for (int b = 0; b < (1 << W); b++)
                    do_op(W'(a), W'(b), ((a + b) % 17) == 0);
        end
        for (int i = 0; i < NRAND; i++)
            do_op(W'($urandom), W'($urandom), (i % 5) == 0);
        fin = 1'b1;
    end

endmodule

module sim_booth_seq_mul;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    int   t4, b4, t8, b8, t16, b16;
    logic f4, f8, f16;

    always #2.5 clk = ~clk;

    sim_lane #(.W(4),  .EXH(1'b1), .NRAND(0))   u_l4  (.clk(clk), .rst_n(rst_n), .total(t4),  .bad(b4),  .fin(f4));
    sim_lane #(.W(8),  .EXH(1'b0), .NRAND(400)) u_l8  (.clk(clk), .rst_n(rst_n), .total(t8),  .bad(b8),  .fin(f8));
    sim_lane #(.W(16), .EXH(1'b0), .NRAND(300)) u_l16 (.clk(clk), .rst_n(rst_n), .total(t16), .bad(b16), .fin(f16));

    initial begin
        int cycles;
        int wd_bad;
        cycles = 0;
        wd_bad = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        while (!(f4 && f8 && f16) && cycles < 150000) begin
            @(negedge clk);
            cycles++;
        end
        if (!(f4 && f8 && f16)) begin
            wd_bad = 1;
            $display("FAIL watchdog expired actual=%0d expected<150000 cycles", cycles);
        end
        repeat (2) @(negedge clk);
        $display("test done: total=%0d bad=%0d", t4 + t8 + t16 + wd_bad, b4 + b8 + b16 + wd_bad);
        $finish;
    end

endmodule